// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Front End

This block is the digital control side of a two-channel, 13-bit voltage-output converter. A host writes 16-bit command words over a three-wire serial port: an active-low select, a serial clock and a data line. The top three bits of each word pick an operation and the low thirteen bits carry a code. Each channel keeps two registers. The staging register is written first. The output register holds the code that actually drives the converter. Because of this split, both channels can be staged separately and then switched in the same cycle.

Commands can also shut down either channel or both, and can set a general-purpose output pin. While the active-low lockout input is held low, no channel can be shut down. An asynchronous active-low clear input empties every register. The serial output carries the shift register's top bit, so several of these blocks can be chained on one data line.

The serial pins are sampled by the block's own clock through a configurable synchronizer. Edges of the serial clock are detected in that single clock domain.

Top module: `dual_dac_serial_front`

## Requirements
- R1: A command runs only when exactly 16 rising serial-clock edges arrive while select is low. Bits enter MSB first, and the command runs when select rises. A frame with any other number of edges changes no output.
- R2: The operation field is bits 15:13 and the code field is bits 12:0. Operation 001 writes the code to staging register A and 010 writes it to staging register B. Neither changes code_a or code_b.
- R3: Operation 011 writes the code to both staging registers and to both output registers, so code_a and code_b both take the code.
- R4: Operation 100 copies each staging register into its output register.
- R5: While lockout_n is high, operation 101 sets sleep_a, 110 sets sleep_b, and 111 sets both. A sleep flag changes at no other time.
- R6: While lockout_n is low, both sleep flags are held at 0 and shutdown operations leave them at 0.
- R7: Operations that address a channel bring it out of shutdown: 001 wakes A, 010 wakes B, and 011 and 100 wake both. Operation 000 changes nothing.
- R8: Operation 111 copies code bit 0 to user_out, whatever the level of lockout_n. No other operation changes user_out.
- R9: spi_miso presents the shift register's top bit and changes only after a falling serial-clock edge inside a frame. Its value therefore repeats spi_mosi 16 clocks later.
- R10: While clr_n is low, without waiting for a clock edge, both codes, all registers, both sleep flags and user_out are 0.
- R11: After rst_n, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_n | input | 1 | Active-low asynchronous clear of all registers |
| lockout_n | input | 1 | While low, no channel may shut down |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, for chaining |
| code_a | output | 13 | Converter code, channel A |
| code_b | output | 13 | Converter code, channel B |
| sleep_a | output | 1 | Channel A shut down |
| sleep_b | output | 1 | Channel B shut down |
| user_out | output | 1 | General-purpose output level |

## Verification
The assertions check on every cycle the rules that do not depend on the data:
- the codes and user_out change only in the cycle after a command runs;
- a sleep flag rises only after a command that arrived while lockout_n was high;
- lockout_n low keeps both channels awake;
- spi_miso moves only after a falling serial-clock edge;
- clear forces everything to zero.

Only the bench's scenarios can show the rest. These are the values loaded by each operation over a sweep of codes, the rejection of 15-, 17- and 32-bit frames, the 16-clock delay on the chained data line, and staging that leaves the output registers untouched.

// File: rtl/dual_dac_serial_pkg.sv
package dual_dac_serial_pkg;
   localparam int NUM_CH = 2;

   typedef enum logic [2:0] {
      OP_NOP       = 3'd0,
      OP_STAGE_A   = 3'd1,
      OP_STAGE_B   = 3'd2,
      OP_LOAD_ALL  = 3'd3,
      OP_COMMIT    = 3'd4,
      OP_SLEEP_A   = 3'd5,
      OP_SLEEP_B   = 3'd6,
      OP_SLEEP_ALL = 3'd7
   } op_e;
endpackage

// File: rtl/dds_pin_sync.sv
module dds_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else if (STAGES == 1) begin : g_one
      logic q_r;
      always_ff @(posedge clk or negedge arst_n)
         if (!arst_n) q_r <= RST_VAL;
         else         q_r <= d_i;
      assign q_o = q_r;
   end else begin : g_chain
      logic [STAGES-1:0] chain_r;
      always_ff @(posedge clk or negedge arst_n)
         if (!arst_n) chain_r <= {STAGES{RST_VAL}};
         else         chain_r <= {chain_r[STAGES-2:0], d_i};
      assign q_o = chain_r[STAGES-1];
   end
endmodule

// File: rtl/dds_shifter.sv
module dds_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              cs_n_i,
   input  logic              sclk_i,
   input  logic              sdi_i,
   output logic [WORD_W-1:0] word_o,
   output logic              exec_o,
   output logic              sdo_o,
   output logic              fall_o
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

   logic              cs_d, sclk_d;
   logic              cs_rise, cs_fall, clk_rise, clk_fall;
   logic [WORD_W-1:0] sr_r;
   logic [CNT_W-1:0]  cnt_r;

   always_ff @(posedge clk or negedge arst_n)
      if (!arst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         cs_d   <= cs_n_i;
         sclk_d <= sclk_i;
      end

   assign cs_rise  =  cs_n_i & ~cs_d;
   assign cs_fall  = ~cs_n_i &  cs_d;
   assign clk_rise =  sclk_i & ~sclk_d & ~cs_n_i;
   assign clk_fall = ~sclk_i &  sclk_d & ~cs_n_i;

   always_ff @(posedge clk or negedge arst_n)
      if (!arst_n) begin
         sr_r   <= '0;
         cnt_r  <= '0;
         exec_o <= 1'b0;
         sdo_o  <= 1'b0;
      end else begin
         if (clk_rise) sr_r <= {sr_r[WORD_W-2:0], sdi_i};
         if (cs_fall)
            cnt_r <= '0;
         else if (clk_rise && cnt_r != CNT_OVER)
            cnt_r <= cnt_r + 1'b1;
         exec_o <= cs_rise && (cnt_r == CNT_FULL);
         if (clk_fall) sdo_o <= sr_r[WORD_W-1];
      end

   assign word_o = sr_r;
   assign fall_o = clk_fall;
endmodule

// File: rtl/dds_chregs.sv
module dds_chregs
   import dual_dac_serial_pkg::*;
#(
   parameter int DATA_W = 13,
   parameter int CTRL_W = 3,
   localparam int WORD_W = DATA_W + CTRL_W
) (
   input  logic                           clk,
   input  logic                           arst_n,
   input  logic                           exec_i,
   input  logic [WORD_W-1:0]              word_i,
   input  logic                           lockout_n_i,
   output logic [NUM_CH-1:0][DATA_W-1:0]  code_o,
   output logic [NUM_CH-1:0]              sleep_o,
   output logic                           user_o
);
   op_e               op;
   logic [DATA_W-1:0] data;

   assign op   = op_e'(word_i[WORD_W-1 -: CTRL_W]);
   assign data = word_i[DATA_W-1:0];

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam op_e STAGE_OP = (ch == 0) ? OP_STAGE_A : OP_STAGE_B;
      localparam op_e SLEEP_OP = (ch == 0) ? OP_SLEEP_A : OP_SLEEP_B;

      logic [DATA_W-1:0] stage_r, out_r;
      logic              sleep_r;
      logic              ld_stage, ld_direct, commit, go_sleep, wake;

      always_comb begin
         ld_stage  = exec_i && (op == STAGE_OP || op == OP_LOAD_ALL);
         ld_direct = exec_i && (op == OP_LOAD_ALL);
         commit    = exec_i && (op == OP_COMMIT);
         go_sleep  = exec_i && (op == SLEEP_OP || op == OP_SLEEP_ALL);
         wake      = ld_stage || commit;
      end

      always_ff @(posedge clk or negedge arst_n)
         if (!arst_n) begin
            stage_r <= '0;
            out_r   <= '0;
            sleep_r <= 1'b0;
         end else begin
            if (ld_stage)  stage_r <= data;
            if (ld_direct) out_r   <= data;
            else if (commit) out_r <= stage_r;
            if (!lockout_n_i)  sleep_r <= 1'b0;
            else if (go_sleep) sleep_r <= 1'b1;
            else if (wake)     sleep_r <= 1'b0;
         end

      assign code_o[ch]  = out_r;
      assign sleep_o[ch] = sleep_r;
   end

   always_ff @(posedge clk or negedge arst_n)
      if (!arst_n)                           user_o <= 1'b0;
      else if (exec_i && op == OP_SLEEP_ALL) user_o <= data[0];
endmodule

// File: rtl/dual_dac_serial_front.sv
module dual_dac_serial_front
   import dual_dac_serial_pkg::*;
#(
   parameter int DATA_W      = 13,
   parameter int CTRL_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              lockout_n,
   input  logic              spi_cs_n,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b,
   output logic              sleep_a,
   output logic              sleep_b,
   output logic              user_out
);
   localparam int WORD_W = DATA_W + CTRL_W;

   if (CTRL_W != 3) begin : g_bad_ctrl
      $error("CTRL_W must be 3 for the operation decode");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic                          arst_n;
   logic                          cs_s, sclk_s, sdi_s;
   logic [WORD_W-1:0]             word_w;
   logic                          exec_w, sclk_fall_w;
   logic [NUM_CH-1:0][DATA_W-1:0] code_w;
   logic [NUM_CH-1:0]             sleep_w;

   assign arst_n = rst_n & clr_n;

   dds_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .arst_n(arst_n), .d_i(spi_cs_n), .q_o(cs_s));
   dds_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .arst_n(arst_n), .d_i(spi_sclk), .q_o(sclk_s));
   dds_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
      .clk(clk), .arst_n(arst_n), .d_i(spi_mosi), .q_o(sdi_s));

   dds_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .arst_n(arst_n),
      .cs_n_i(cs_s), .sclk_i(sclk_s), .sdi_i(sdi_s),
      .word_o(word_w), .exec_o(exec_w), .sdo_o(spi_miso), .fall_o(sclk_fall_w));

   dds_chregs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
      .clk(clk), .arst_n(arst_n), .exec_i(exec_w), .word_i(word_w),
      .lockout_n_i(lockout_n), .code_o(code_w), .sleep_o(sleep_w), .user_o(user_out));

   assign code_a  = code_w[0];
   assign code_b  = code_w[1];
   assign sleep_a = sleep_w[0];
   assign sleep_b = sleep_w[1];
endmodule

// File: rtl/dual_dac_serial_chk.sv
module dual_dac_serial_chk #(
   parameter int DATA_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_n,
   input logic              lockout_n,
   input logic              exec,
   input logic              sclk_fall,
   input logic              spi_miso,
   input logic [DATA_W-1:0] code_a,
   input logic [DATA_W-1:0] code_b,
   input logic              sleep_a,
   input logic              sleep_b,
   input logic              user_out
);
   a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (code_a == '0 && code_b == '0 && !sleep_a && !sleep_b && !user_out));

   a_r6_lockout_awake: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !lockout_n |=> (!sleep_a && !sleep_b));

   a_r2_code_a_on_cmd: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !$stable(code_a) |-> $past(exec));

   a_r2_code_b_on_cmd: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !$stable(code_b) |-> $past(exec));

   a_r5_sleep_a_rise: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      $rose(sleep_a) |-> ($past(exec) && $past(lockout_n)));

   a_r5_sleep_b_rise: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      $rose(sleep_b) |-> ($past(exec) && $past(lockout_n)));

   a_r7_wake_cause: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      ($fell(sleep_a) || $fell(sleep_b)) |-> ($past(exec) || !$past(lockout_n)));

   a_r8_user_on_cmd: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !$stable(user_out) |-> $past(exec));

   a_r9_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !$stable(spi_miso) |-> $past(sclk_fall));
endmodule

bind dual_dac_serial_front dual_dac_serial_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .lockout_n(lockout_n),
   .exec(exec_w), .sclk_fall(sclk_fall_w), .spi_miso(spi_miso),
   .code_a(code_a), .code_b(code_b), .sleep_a(sleep_a), .sleep_b(sleep_b),
   .user_out(user_out));

// File: tb/dual_dac_serial_front_bench.sv
`timescale 1ns/1ps
module dual_dac_serial_front_bench;
   logic clk = 1'b0, rst_n = 1'b0, clr_n = 1'b1, lockout_n = 1'b1;
   logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
   logic miso, sleep_a, sleep_b, user_out;
   logic [12:0] code_a, code_b;

   dual_dac_serial_front u_dual_dac_serial_front (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .lockout_n(lockout_n),
      .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
      .code_a(code_a), .code_b(code_b), .sleep_a(sleep_a), .sleep_b(sleep_b),
      .user_out(user_out));

   always #4 clk = ~clk;

   int total = 0, bad = 0;
   logic [12:0] m_sa_in, m_sb_in, m_da, m_db;
   logic        m_sla, m_slb, m_uo;
   logic [63:0] seen;
   logic [15:0] lf = 16'hACE1;

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [63:0] bits, input int n);
      cs_n = 1'b0;
      wait_clk(4);
      for (int i = 0; i < n; i++) begin
         mosi = bits[n-1-i];
         wait_clk(8);
         seen[n-1-i] = miso;
         sclk = 1'b1;
         wait_clk(8);
         sclk = 1'b0;
      end
      wait_clk(8);
      cs_n = 1'b1;
      wait_clk(12);
   endtask

   task automatic model_apply(input logic [15:0] w);
      logic [12:0] d;
      d = w[12:0];
      case (w[15:13])
         3'd1: begin m_sa_in = d; m_sla = 1'b0; end
         3'd2: begin m_sb_in = d; m_slb = 1'b0; end
         3'd3: begin m_sa_in = d; m_sb_in = d; m_da = d; m_db = d; m_sla = 1'b0; m_slb = 1'b0; end
         3'd4: begin m_da = m_sa_in; m_db = m_sb_in; m_sla = 1'b0; m_slb = 1'b0; end
         3'd5: if (lockout_n) m_sla = 1'b1;
         3'd6: if (lockout_n) m_slb = 1'b1;
         3'd7: begin if (lockout_n) begin m_sla = 1'b1; m_slb = 1'b1; end m_uo = d[0]; end
         default: ;
      endcase
      if (!lockout_n) begin m_sla = 1'b0; m_slb = 1'b0; end
   endtask

   task automatic check_all(input string req);
      chk(req, "code_a", int'(code_a), int'(m_da));
      chk(req, "code_b", int'(code_b), int'(m_db));
      chk(req, "sleep_a", int'(sleep_a), int'(m_sla));
      chk(req, "sleep_b", int'(sleep_b), int'(m_slb));
      chk(req, "user_out", int'(user_out), int'(m_uo));
   endtask

   function automatic string op_req(input logic [2:0] op);
      case (op)
         3'd0: return "R7";
         3'd1, 3'd2: return "R2";
         3'd3: return "R3";
         3'd4: return "R4";
         3'd5, 3'd6: return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic frame(input logic [15:0] w);
      send_bits({48'd0, w}, 16);
      model_apply(w);
      check_all(op_req(w[15:13]));
   endtask

   task automatic model_clear();
      m_sa_in = '0; m_sb_in = '0; m_da = '0; m_db = '0;
      m_sla = 1'b0; m_slb = 1'b0; m_uo = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [12:0] pats [6];
      pats = '{13'd0, 13'd8191, 13'd1, 13'd4096, 13'h0AAA, 13'h1555};
      model_clear();
      wait_clk(3);
      check_all("R11");
      chk("R11", "miso", int'(miso), 0);
      rst_n = 1'b1;
      wait_clk(4);

      // sweep of every operation over corner codes: R2 R3 R4 R5 R7 R8
      for (int op = 0; op < 8; op++)
         for (int p = 0; p < 6; p++)
            frame({3'(op), pats[p]});
      for (int k = 0; k < 40; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         frame(lf);
      end

      // R2: staging alone leaves outputs; R4 commit moves them
      frame({3'd3, 13'd100});
      frame({3'd1, 13'd7000});
      frame({3'd2, 13'd321});
      chk("R2", "code_a held", int'(code_a), 100);
      frame({3'd4, 13'd0});
      chk("R4", "code_a committed", int'(code_a), 7000);
      chk("R4", "code_b committed", int'(code_b), 321);

      // R1: 15 and 17 edge frames ignored
      send_bits({48'd0, 3'd3, 13'd55} >> 1, 15);
      check_all("R1");
      send_bits({47'd0, 3'd3, 13'd55, 1'b0}, 17);
      check_all("R1");

      // R7: wake by addressed load
      frame({3'd7, 13'd0});
      frame({3'd1, 13'd9});
      chk("R7", "sleep_a woken", int'(sleep_a), 0);
      chk("R7", "sleep_b kept", int'(sleep_b), 1);

      // R6: lockout clears and blocks shutdown; R8 still sets user_out
      frame({3'd7, 13'd0});
      lockout_n = 1'b0;
      wait_clk(3);
      m_sla = 1'b0; m_slb = 1'b0;
      check_all("R6");
      frame({3'd7, 13'd1});
      chk("R6", "sleep_a under lockout", int'(sleep_a), 0);
      chk("R8", "user_out under lockout", int'(user_out), 1);
      frame({3'd5, 13'd0});
      lockout_n = 1'b1;
      wait_clk(3);
      frame({3'd5, 13'd0});
      chk("R5", "sleep_a after lockout", int'(sleep_a), 1);

      // R9: 32 edge chain, output lags input by 16 clocks; R1 frame ignored
      send_bits({32'd0, 16'hB3C5, 16'h2A71}, 32);
      chk("R9", "chain first word", int'(seen[15:0]), 16'hB3C5);
      check_all("R1");
      send_bits({48'd0, 16'h0000}, 16);
      chk("R9", "chain second word", int'(seen[15:0]), 16'h2A71);
      model_apply(16'h0000);
      check_all("R7");

      // R10: asynchronous clear
      frame({3'd3, 13'd4321});
      frame({3'd7, 13'd1});
      @(negedge clk);
      #1 clr_n = 1'b0;
      #1;
      model_clear();
      check_all("R10");
      wait_clk(3);
      clr_n = 1'b1;
      wait_clk(3);
      frame({3'd4, 13'd0});
      chk("R10", "staging cleared", int'(code_a), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule